// File: doc/BRIEF.md
# Memory Chip-Select Decoder with Relocatable Internal RAM Window

This block turns a 24-bit CPU address into active-low select strobes for three external memory regions, plus a hit signal for an 8 KB on-chip RAM window. The board's paged SRAM region is split between two devices, and each device has its own active-low bank strobe. All select outputs are combinational from the address, the request strobes and the two configuration registers. They are valid in the same cycle as the access.

The internal RAM window always covers the top 8 KB of some 64 KB page. A page register holds the upper address byte that picks the page, and a control register holds the window enable. Software reaches both registers through I/O cycles, where the low address byte selects the register. A write takes effect at the next clock edge. When the window is enabled and an access falls inside it, the window wins over every external region, and no external strobe is driven. A memory access that matches no region raises an unmapped flag in the following cycle.

Top module: `mem_select_decoder`

## Requirements
- R1: After reset, the page register reads FFh, the control register reads 80h (window enabled), and addresses FFE000h–FFFFFFh hit the internal RAM.
- R2: While `mreq` is high and the window is enabled, `iram_hit` is high exactly when addr[23:16] equals the page register and addr[15:13] are all ones.
- R3: Whenever `iram_hit` is high, every `cs_n` bit and every `bank_n` bit is high, even if the address also lies in an external region.
- R4: When control bit 7 is 0, `iram_hit` stays low, and the external decode applies to the addresses the window would have covered.
- R5: `cs_n[0]` is low for memory accesses to 000000h–3FFFFFh.
- R6: `cs_n[1]` is low for memory accesses to B00000h–BFFFFFh.
- R7: `cs_n[2]` is low for memory accesses to A00000h–AFFFFFh. Within that region, `bank_n[0]` is low for A00000h–A7FFFFh and `bank_n[1]` is low for A80000h–AFFFFFh. Both bank strobes are high at all other times.
- R8: Selects and `iram_hit` are driven only while `mreq` is high, so an I/O cycle (`ioreq`) never drives them. At most one `cs_n` bit is low at a time.
- R9: An I/O cycle with `io_wr` high writes the page register at I/O address 60h, or the control register at 61h, where only bit 7 (enable) is stored. The new value takes effect at the next rising clock edge. `io_rdata` returns the register selected by an I/O cycle at 60h or 61h, and returns 00h for any other address or when no I/O cycle is active.
- R10: `unmapped` is high in the cycle after a memory access that hit neither the window nor any external region, and low otherwise.
- R11: An address in the selected page but below the top 8 KB (addr[15:13] not all ones) does not hit the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 24 | CPU address; low byte is the I/O register address |
| mreq | input | 1 | Memory request |
| ioreq | input | 1 | I/O request |
| io_wr | input | 1 | I/O write qualifier |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Register readback |
| cs_n | output | 3 | Active-low external region selects (0 flash, 1 module SRAM, 2 board SRAM) |
| bank_n | output | 2 | Active-low board SRAM device selects |
| iram_hit | output | 1 | Internal RAM window hit |
| unmapped | output | 1 | Previous-cycle memory access matched nothing |

## Verification
A vector table probes the first and last address of each external region and of each board SRAM device. It also probes the addresses just outside those regions, which exposes off-by-one range masks and swapped bank strobes. I/O-only and request-free cycles at in-range addresses separate strobe gating from address decoding. Directed tests then move the window onto an address in the flash region and onto one in the board SRAM region, which shows whether the window's priority really blocks the external strobes. Further directed tests disable the window, which shows whether the external decode takes those addresses back. They also check that a register write has no effect before the clock edge and does afterwards.

// File: rtl/msel_regs.sv
module msel_regs #(
  parameter int DATA_W  = 8,
  parameter int PAGE_W  = 8,
  parameter int IOA_W   = 8,
  parameter int EN_BIT  = 7,
  parameter logic [IOA_W-1:0] IO_PAGE = 8'h60,
  parameter logic [IOA_W-1:0] IO_CTRL = 8'h61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ioreq,
  input  logic              io_wr,
  input  logic [IOA_W-1:0]  io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic [PAGE_W-1:0] page,
  output logic              win_en
);
  logic wr_page, wr_ctrl;

  assign wr_page = ioreq & io_wr & (io_addr == IO_PAGE);
  assign wr_ctrl = ioreq & io_wr & (io_addr == IO_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page   <= '1;
      win_en <= 1'b1;
    end else begin
      if (wr_page) page   <= io_wdata[PAGE_W-1:0];
      if (wr_ctrl) win_en <= io_wdata[EN_BIT];
    end
  end

  always_comb begin
    io_rdata = '0;
    if (ioreq && io_addr == IO_PAGE) io_rdata[PAGE_W-1:0] = page;
    else if (ioreq && io_addr == IO_CTRL) io_rdata[EN_BIT] = win_en;
  end

  // R9: a register write is visible right after the next edge
  a_r9_page_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_page |=> (page == $past(io_wdata[PAGE_W-1:0])));
  a_r9_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (win_en == $past(io_wdata[EN_BIT])));
endmodule

// File: rtl/msel_ramwin.sv
module msel_ramwin #(
  parameter int ADDR_W    = 24,
  parameter int PAGE_LOG2 = 16,
  parameter int WIN_LOG2  = 13,
  localparam int PAGE_W   = ADDR_W - PAGE_LOG2,
  localparam int HI_W     = ADDR_W - WIN_LOG2
) (
  input  logic [HI_W-1:0]   addr_hi,
  input  logic [PAGE_W-1:0] page,
  input  logic              win_en,
  input  logic              mreq,
  output logic              hit
);
  function automatic logic win_match(input logic [HI_W-1:0] a,
                                     input logic [PAGE_W-1:0] pg);
    logic top_slot;
    top_slot = &a[PAGE_LOG2-WIN_LOG2-1:0];
    return (a[HI_W-1 -: PAGE_W] == pg) && top_slot;
  endfunction

  assign hit = mreq & win_en & win_match(addr_hi, page);
endmodule

// File: rtl/msel_extdec.sv
module msel_extdec #(
  parameter int ADDR_W  = 24,
  parameter int N_CS    = 3,
  parameter logic [N_CS*ADDR_W-1:0] BASES = {24'hA00000, 24'hB00000, 24'h000000},
  parameter logic [N_CS*5-1:0]      SPANS = {5'd20, 5'd20, 5'd22},
  parameter int BANK_CS = 2,
  parameter int N_BANK  = 2,
  localparam int BANK_BITS = (N_BANK > 1) ? $clog2(N_BANK) : 1,
  localparam int BANK_SPAN = int'(SPANS[BANK_CS*5 +: 5])
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq,
  input  logic              block,
  output logic [N_CS-1:0]   cs_n,
  output logic [N_BANK-1:0] bank_n,
  output logic              any_range
);
  function automatic logic region_hit(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] base,
                                      input logic [4:0] span);
    logic [ADDR_W-1:0] keep;
    keep = {ADDR_W{1'b1}} << span;
    return (a & keep) == (base & keep);
  endfunction

  logic [N_CS-1:0]      in_rng;
  logic [N_CS-1:0]      grant;
  logic                 active;
  logic [BANK_BITS-1:0] bank_idx;

  for (genvar i = 0; i < N_CS; i++) begin : g_rng
    assign in_rng[i] = region_hit(addr, BASES[i*ADDR_W +: ADDR_W], SPANS[i*5 +: 5]);
  end

  // lowest index wins if ranges ever overlap
  always_comb begin
    grant = '0;
    for (int k = 0; k < N_CS; k++)
      if (in_rng[k] && grant == '0) grant[k] = 1'b1;
  end

  assign active    = mreq & ~block;
  assign cs_n      = ~({N_CS{active}} & grant);
  assign any_range = |in_rng;
  assign bank_idx  = addr[BANK_SPAN-1 -: BANK_BITS];

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    assign bank_n[b] = ~(active & grant[BANK_CS] & (bank_idx == BANK_BITS'(b)));
  end
endmodule

// File: rtl/mem_select_decoder.sv
module mem_select_decoder #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int PAGE_LOG2 = 16,
  parameter int WIN_LOG2  = 13,
  parameter int N_CS      = 3,
  parameter int N_BANK    = 2,
  parameter int BANK_CS   = 2,
  parameter int IOA_W     = 8,
  parameter int EN_BIT    = 7,
  parameter logic [IOA_W-1:0] IO_PAGE = 8'h60,
  parameter logic [IOA_W-1:0] IO_CTRL = 8'h61,
  parameter logic [N_CS*ADDR_W-1:0] BASES = {24'hA00000, 24'hB00000, 24'h000000},
  parameter logic [N_CS*5-1:0]      SPANS = {5'd20, 5'd20, 5'd22}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq,
  input  logic              ioreq,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic [N_CS-1:0]   cs_n,
  output logic [N_BANK-1:0] bank_n,
  output logic              iram_hit,
  output logic              unmapped
);
  localparam int PAGE_W = ADDR_W - PAGE_LOG2;

  logic [PAGE_W-1:0] page;
  logic              win_en;
  logic              ext_any;
  logic              miss_now;

  msel_regs #(
    .DATA_W(DATA_W), .PAGE_W(PAGE_W), .IOA_W(IOA_W), .EN_BIT(EN_BIT),
    .IO_PAGE(IO_PAGE), .IO_CTRL(IO_CTRL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .ioreq(ioreq), .io_wr(io_wr),
    .io_addr(addr[IOA_W-1:0]), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .page(page), .win_en(win_en)
  );

  msel_ramwin #(
    .ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2), .WIN_LOG2(WIN_LOG2)
  ) u_win (
    .addr_hi(addr[ADDR_W-1:WIN_LOG2]), .page(page), .win_en(win_en),
    .mreq(mreq), .hit(iram_hit)
  );

  msel_extdec #(
    .ADDR_W(ADDR_W), .N_CS(N_CS), .BASES(BASES), .SPANS(SPANS),
    .BANK_CS(BANK_CS), .N_BANK(N_BANK)
  ) u_ext (
    .addr(addr), .mreq(mreq), .block(iram_hit),
    .cs_n(cs_n), .bank_n(bank_n), .any_range(ext_any)
  );

  assign miss_now = mreq & ~iram_hit & ~ext_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unmapped <= 1'b0;
    else        unmapped <= miss_now;
  end

  // R3: window hit blocks every external strobe
  a_r3_window_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    iram_hit |-> ((&cs_n) && (&bank_n)));
  // R8: at most one region strobe
  a_r8_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R8: nothing without a memory request
  a_r8_needs_mreq: assert property (@(posedge clk) disable iff (!rst_n)
    !mreq |-> ((&cs_n) && !iram_hit));
  // R7: a bank strobe only under the board SRAM select
  a_r7_bank_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&bank_n)) |-> !cs_n[BANK_CS]);
  // R4: disabled window is silent
  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> !iram_hit);
  // R10: an unclaimed memory access flags one cycle later
  a_r10_unmapped_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq && (&cs_n) && !iram_hit) |=> unmapped);
endmodule

// File: tb/mem_select_decoder_tb.sv
module mem_select_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        mreq = 1'b0, ioreq = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [2:0]  cs_n;
  logic [1:0]  bank_n;
  logic        iram_hit, unmapped;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mem_select_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq(mreq), .ioreq(ioreq),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata), .cs_n(cs_n),
    .bank_n(bank_n), .iram_hit(iram_hit), .unmapped(unmapped)
  );

  // {req, addr, mreq, ioreq, cs_n, bank_n, hit} with reset register values
  localparam int NV = 16;
  localparam logic [35:0] VEC [NV] = '{
    {4'd5,  24'h000000, 2'b10, 3'b110, 2'b11, 1'b0},  // R5 low edge
    {4'd5,  24'h3FFFFF, 2'b10, 3'b110, 2'b11, 1'b0},  // R5 high edge
    {4'd10, 24'h400000, 2'b10, 3'b111, 2'b11, 1'b0},  // R10 just past flash
    {4'd6,  24'hB00000, 2'b10, 3'b101, 2'b11, 1'b0},  // R6
    {4'd6,  24'hBFFFFF, 2'b10, 3'b101, 2'b11, 1'b0},  // R6
    {4'd7,  24'hA00000, 2'b10, 3'b011, 2'b10, 1'b0},  // R7 device 0
    {4'd7,  24'hA7FFFF, 2'b10, 3'b011, 2'b10, 1'b0},  // R7 device 0 top
    {4'd7,  24'hA80000, 2'b10, 3'b011, 2'b01, 1'b0},  // R7 device 1
    {4'd7,  24'hAFFFFF, 2'b10, 3'b011, 2'b01, 1'b0},  // R7 device 1 top
    {4'd1,  24'hFFE000, 2'b10, 3'b111, 2'b11, 1'b1},  // R1 window base
    {4'd2,  24'hFFFFFF, 2'b10, 3'b111, 2'b11, 1'b1},  // R2 window top
    {4'd11, 24'hFFDFFF, 2'b10, 3'b111, 2'b11, 1'b0},  // R11 below window
    {4'd8,  24'h000000, 2'b01, 3'b111, 2'b11, 1'b0},  // R8 I/O cycle
    {4'd8,  24'hA00000, 2'b00, 3'b111, 2'b11, 1'b0},  // R8 idle
    {4'd10, 24'h9FFFFF, 2'b10, 3'b111, 2'b11, 1'b0},  // R10 below board SRAM
    {4'd10, 24'hC00000, 2'b10, 3'b111, 2'b11, 1'b0}   // R10 above module SRAM
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mem_cycle(input logic [23:0] a);
    @(negedge clk);
    ioreq = 1'b0; io_wr = 1'b0; mreq = 1'b1; addr = a;
    #1;
  endtask

  task automatic io_write(input logic [7:0] ia, input logic [7:0] d);
    @(negedge clk);
    mreq = 1'b0; ioreq = 1'b1; io_wr = 1'b1; addr = {16'h0, ia}; io_wdata = d;
    @(negedge clk);
    ioreq = 1'b0; io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] ia, output logic [7:0] d);
    @(negedge clk);
    mreq = 1'b0; ioreq = 1'b1; io_wr = 1'b0; addr = {16'h0, ia};
    #1 d = io_rdata;
  endtask

  task automatic expect_sel(input string req, input logic [2:0] ecs,
                            input logic [1:0] ebk, input logic ehit);
    check(cs_n == ecs && bank_n == ebk && iram_hit == ehit, req,
          {26'h0, cs_n, bank_n, iram_hit}, {26'h0, ecs, ebk, ehit});
  endtask

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cs_n == 3'b111 && bank_n == 2'b11 && !iram_hit && !unmapped, "R1",
          {27'h0, cs_n, bank_n}, {27'h0, 3'b111, 2'b11});
    rst_n = 1'b1;
    io_read(8'h60, rd); check(rd == 8'hFF, "R1", rd, 8'hFF);
    io_read(8'h61, rd); check(rd == 8'h80, "R1", rd, 8'h80);
    io_read(8'h62, rd); check(rd == 8'h00, "R9", rd, 8'h00);
    ioreq = 1'b0;

    for (int v = 0; v < NV; v++) begin
      logic [3:0]  rq;
      logic        em;
      rq = VEC[v][35:32];
      @(negedge clk);
      addr = VEC[v][31:8]; mreq = VEC[v][7]; ioreq = VEC[v][6]; io_wr = 1'b0;
      #1 check(cs_n == VEC[v][5:3] && bank_n == VEC[v][2:1] && iram_hit == VEC[v][0],
               $sformatf("R%0d", rq), {26'h0, cs_n, bank_n, iram_hit},
               {26'h0, VEC[v][5:0]});
      em = VEC[v][7] && VEC[v][5:3] == 3'b111 && !VEC[v][0];
      @(negedge clk);
      check(unmapped == em, "R10", {31'h0, unmapped}, {31'h0, em});
    end

    // R9: write not visible before the edge, visible after
    @(negedge clk);
    mreq = 1'b0; ioreq = 1'b1; io_wr = 1'b1; addr = 24'h000060; io_wdata = 8'h00;
    #1 check(io_rdata == 8'hFF, "R9", io_rdata, 8'hFF);
    @(negedge clk);
    io_wr = 1'b0;
    #1 check(io_rdata == 8'h00, "R9", io_rdata, 8'h00);

    // R3: window moved onto flash region
    mem_cycle(24'h00E000); expect_sel("R3", 3'b111, 2'b11, 1'b1);
    mem_cycle(24'h00FFFF); expect_sel("R3", 3'b111, 2'b11, 1'b1);
    mem_cycle(24'h00DFFF); expect_sel("R11", 3'b110, 2'b11, 1'b0);
    mem_cycle(24'hFFE000); expect_sel("R2", 3'b111, 2'b11, 1'b0);

    // R2: window over board SRAM device 1
    io_write(8'h60, 8'hA8);
    mem_cycle(24'hA8E123); expect_sel("R2", 3'b111, 2'b11, 1'b1);
    mem_cycle(24'hA8C000); expect_sel("R11", 3'b011, 2'b01, 1'b0);

    // R4: disable window, external decode returns
    io_write(8'h61, 8'h7F);
    io_read(8'h61, rd); check(rd == 8'h00, "R4", rd, 8'h00);
    mem_cycle(24'hA8E123); expect_sel("R4", 3'b011, 2'b01, 1'b0);
    io_write(8'h60, 8'hFF);
    mem_cycle(24'hFFE000); expect_sel("R4", 3'b111, 2'b11, 1'b0);
    @(negedge clk);
    check(unmapped == 1'b1, "R10", {31'h0, unmapped}, 32'h1);
    mem_cycle(24'h100000); expect_sel("R5", 3'b110, 2'b11, 1'b0);
    @(negedge clk);
    check(unmapped == 1'b0, "R10", {31'h0, unmapped}, 32'h0);

    // R9: re-enable with only bit 7 set
    io_write(8'h61, 8'h80);
    mem_cycle(24'hFFF000); expect_sel("R9", 3'b111, 2'b11, 1'b1);

    // R1: reset mid-run restores defaults
    io_write(8'h60, 8'h12);
    io_write(8'h61, 8'h00);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    io_read(8'h60, rd); check(rd == 8'hFF, "R1", rd, 8'hFF);
    io_read(8'h61, rd); check(rd == 8'h80, "R1", rd, 8'h80);
    mem_cycle(24'hFFE000); expect_sel("R1", 3'b111, 2'b11, 1'b1);

    @(negedge clk); mreq = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule